// File: doc/BRIEF.md
# System Control Register File

This block is a bank of 32-bit control words on a simple word-addressed peripheral bus with APB-style select and enable. The two low bits of the byte address are dropped to form a word index. A read returns the addressed word combinationally in the same cycle, with no wait states. A write is captured on the clock edge where select, enable and write are all high.

Most words are plain storage. A few are protected:
- A PLL status word and three memory-remap words refuse bus writes and keep their value.
- A remap write whose data differs from the current contents raises a one-cycle "remap unsupported" pulse.
- An access beyond the end of the array returns zero, changes nothing and raises a one-cycle bad-access pulse.

At reset, a clock-configuration word is loaded with a compact code for each of two bus clock divisors. The divisors are build-time parameters, and a parameter that is not a power of two in 1..32 stops elaboration. The block only stores and returns values: it drives no clock, PLL or address map.

Top module: `sysctl_regfile`

## Requirements
- R1: The word index is the byte address shifted right by two. The low two address bits have no effect on which word is read or written.
- R2: A write to a plain word (not listed in R5 to R8) stores the write data, and later reads of that word return it.
- R3: A read whose word index is 64 or more returns zero on the read data port and pulses `bad_access` high in the cycle after the access phase.
- R4: A write whose word index is 64 or more changes no stored word, including the word whose index it would alias to, and pulses `bad_access` in the cycle after the access phase.
- R5: Word 8 (byte 0x20) resets to 0x021A2358 and is writable.
- R6: Word 9 (byte 0x24) resets to 0x00000003, and bus writes to it leave it unchanged.
- R7: Words 0, 1 and 2 (bytes 0x00, 0x04, 0x08) read as zero and never store written data. A write to one of them whose data differs from its current contents pulses `remap_unsup` in the cycle after the access phase. An equal-valued write pulses nothing.
- R8: Word 4 (byte 0x10) resets to the code of divisor A in bits 7:5 and the code of divisor B in bits 4:2, with all other bits zero. The word is writable afterwards.
- R9: The code of a divisor d is its count of trailing zero bits when d is below 8, and that count plus one when d is 8 or more (1→0, 2→1, 4→2, 8→4, 16→5, 32→6).
- R10: Words with no reset value listed above reset to zero.
- R11: `bad_access` and `remap_unsup` are low after reset and are one-cycle pulses. A select without enable (setup phase) raises neither, and in-range accesses never raise `bad_access`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Block select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (10) | Byte address |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, valid while selected |
| bad_access | output | 1 | One-cycle pulse after an out-of-range access |
| remap_unsup | output | 1 | One-cycle pulse after a differing write to a remap word |

## Verification
The bench builds two copies side by side on a shared bus. One uses divisors 32 and 8, which lands on the largest legal divisor and on the plus-one branch of the code. The other uses divisors 1 and 4, which covers the zero code and the plain trailing-zero branch. With a 10-bit byte address, out-of-range indices up to 255 are reachable, including one that would alias onto a stored word if the range check were missing.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned IDX_MAP_SRAM = 0;
  localparam int unsigned IDX_MAP_DDR  = 1;
  localparam int unsigned IDX_MAP_NVM  = 2;
  localparam int unsigned IDX_CLKCFG   = 4;
  localparam int unsigned IDX_PLL_LO   = 8;
  localparam int unsigned IDX_PLL_ST   = 9;

  localparam logic [31:0] PLL_LO_INIT = 32'h021A_2358;
  localparam logic [31:0] PLL_ST_INIT = 32'h0000_0003;

  localparam int unsigned CODE_A_LSB = 5;
  localparam int unsigned CODE_B_LSB = 2;

  typedef enum logic [1:0] {
    CLS_PLAIN  = 2'd0,
    CLS_LOCKED = 2'd1,
    CLS_REMAP  = 2'd2
  } wclass_e;

  function automatic logic [2:0] div_code(int unsigned d);
    int unsigned tz;
    tz = 0;
    for (int b = 0; b < 6; b++) begin
      if (((d >> b) & 1) == 0 && tz == b) tz = b + 1;
    end
    return (d < 8) ? 3'(tz) : 3'(tz + 1);
  endfunction

  function automatic logic div_ok(int unsigned d);
    return (d != 0) && (d <= 32) && ((d & (d - 1)) == 0);
  endfunction

  function automatic wclass_e word_class(int unsigned idx);
    if (idx == IDX_MAP_SRAM || idx == IDX_MAP_DDR || idx == IDX_MAP_NVM) return CLS_REMAP;
    if (idx == IDX_PLL_ST) return CLS_LOCKED;
    return CLS_PLAIN;
  endfunction

  function automatic logic [31:0] init_word(int unsigned idx, int unsigned da, int unsigned db);
    logic [31:0] w;
    w = '0;
    if (idx == IDX_PLL_LO) w = PLL_LO_INIT;
    else if (idx == IDX_PLL_ST) w = PLL_ST_INIT;
    else if (idx == IDX_CLKCFG) begin
      w[CODE_A_LSB +: 3] = div_code(da);
      w[CODE_B_LSB +: 3] = div_code(db);
    end
    return w;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned NUM_WORDS = 64,
  localparam int unsigned SEL_W    = $clog2(NUM_WORDS)
) (
  input  logic [ADDR_W-1:0] paddr,
  output logic [SEL_W-1:0]  sel,
  output logic              in_range,
  output wclass_e           wclass
);
  logic [1:0] unused_byte_lanes;

  assign unused_byte_lanes = paddr[1:0];
  assign sel      = paddr[SEL_W+1:2];
  assign in_range = (32'(paddr) >> 2) < NUM_WORDS;
  assign wclass   = word_class(32'(sel));
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DIV_A     = 2,
  parameter int unsigned DIV_B     = 2,
  localparam int unsigned SEL_W    = $clog2(NUM_WORDS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              store_en,
  input  logic [SEL_W-1:0]                  sel,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]  words
);
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    localparam logic [DATA_W-1:0] INIT = DATA_W'(init_word(i, DIV_A, DIV_B));
    if (word_class(i) == CLS_PLAIN) begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= INIT;
        else if (store_en && sel == SEL_W'(i)) q <= wdata;
      end
      assign words[i] = q;
    end else begin : g_fixed
      assign words[i] = INIT;
    end
  end
endmodule

// File: rtl/sysctl_events.sv
module sysctl_events
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_fire,
  input  logic              wr_fire,
  input  logic              in_range,
  input  wclass_e           wclass,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cur_word,
  output logic              bad_access,
  output logic              remap_unsup
);
  logic bad_ev, remap_ev;

  assign bad_ev   = acc_fire && !in_range;
  assign remap_ev = wr_fire && in_range && (wclass == CLS_REMAP) && (wdata != cur_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_access  <= 1'b0;
      remap_unsup <= 1'b0;
    end else begin
      bad_access  <= bad_ev;
      remap_unsup <= remap_ev;
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned DIV_A     = 2,
  parameter int unsigned DIV_B     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              bad_access,
  output logic              remap_unsup
);
  localparam int unsigned SEL_W = $clog2(NUM_WORDS);

  if (!div_ok(DIV_A) || !div_ok(DIV_B)) begin : g_bad_divisor
    $fatal(1, "sysctl_regfile: divisors must be powers of two from 1 to 32");
  end

  logic [SEL_W-1:0]                 sel;
  logic                             in_range;
  wclass_e                          wclass;
  logic                             acc_fire, wr_fire, store_en;
  logic [NUM_WORDS-1:0][DATA_W-1:0] words;
  logic [DATA_W-1:0]                cur_word;
  logic [DATA_W-1:0]                pll_lo_word, pll_st_word;

  assign acc_fire    = psel && penable;
  assign wr_fire     = acc_fire && pwrite;
  assign store_en    = wr_fire && in_range;
  assign cur_word    = words[sel];
  assign pll_lo_word = words[IDX_PLL_LO];
  assign pll_st_word = words[IDX_PLL_ST];
  assign prdata      = (psel && in_range) ? cur_word : '0;

  sysctl_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_decode (
    .paddr(paddr), .sel(sel), .in_range(in_range), .wclass(wclass)
  );

  sysctl_bank #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .DIV_A(DIV_A), .DIV_B(DIV_B)) u_bank (
    .clk(clk), .rst_n(rst_n), .store_en(store_en), .sel(sel), .wdata(pwdata), .words(words)
  );

  sysctl_events #(.DATA_W(DATA_W)) u_events (
    .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire), .wr_fire(wr_fire), .in_range(in_range),
    .wclass(wclass), .wdata(pwdata), .cur_word(cur_word),
    .bad_access(bad_access), .remap_unsup(remap_unsup)
  );
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              acc_fire,
  input logic              wr_fire,
  input logic              in_range,
  input logic [SEL_W-1:0]  sel,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic [DATA_W-1:0] pll_lo_word,
  input logic [DATA_W-1:0] pll_st_word,
  input logic              bad_access,
  input logic              remap_unsup
);
  assert_store_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && in_range && sel == SEL_W'(IDX_PLL_LO)) |=> (pll_lo_word == $past(pwdata)));

  assert_oor_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !in_range) |-> (prdata == '0));

  assert_oor_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !in_range) |=> bad_access);

  assert_bad_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(acc_fire && !in_range));

  assert_status_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && sel == SEL_W'(IDX_PLL_ST)) |=> (pll_st_word == DATA_W'(PLL_ST_INIT)));

  assert_remap_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    remap_unsup |-> $past(wr_fire && in_range && sel <= SEL_W'(IDX_MAP_NVM)));

  assert_bad_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |=> !bad_access);
endmodule

bind sysctl_regfile sysctl_regfile_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .acc_fire(acc_fire), .wr_fire(wr_fire),
  .in_range(in_range), .sel(sel), .pwdata(pwdata), .prdata(prdata),
  .pll_lo_word(pll_lo_word), .pll_st_word(pll_st_word),
  .bad_access(bad_access), .remap_unsup(remap_unsup)
);

// File: tb/tb_sysctl_regfile.sv
module tb_sysctl_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [9:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata2;
  logic        bad_access, remap_unsup, bad2, remap2;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sysctl_regfile #(.DIV_A(32), .DIV_B(8)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .bad_access(bad_access), .remap_unsup(remap_unsup)
  );

  sysctl_regfile #(.DIV_A(1), .DIV_B(4)) dut2 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata2),
    .bad_access(bad2), .remap_unsup(remap2)
  );

  typedef struct packed {
    logic [9:0]  waddr;
    logic [31:0] wdata;
    logic [9:0]  raddr;
    logic [31:0] rexp;
    logic        ebad;
    logic        eremap;
  } vec_t;

  // R2, R1, R6, R7 x3, R4 alias, R5, R8, R4 top index
  localparam vec_t VECS [10] = '{
    '{10'h030, 32'hDEADBEEF, 10'h030, 32'hDEADBEEF, 1'b0, 1'b0},
    '{10'h033, 32'h12345678, 10'h031, 32'h12345678, 1'b0, 1'b0},
    '{10'h024, 32'hAAAA5555, 10'h024, 32'h00000003, 1'b0, 1'b0},
    '{10'h000, 32'h00000001, 10'h000, 32'h00000000, 1'b0, 1'b1},
    '{10'h004, 32'h00000000, 10'h004, 32'h00000000, 1'b0, 1'b0},
    '{10'h008, 32'hFFFFFFFF, 10'h008, 32'h00000000, 1'b0, 1'b1},
    '{10'h230, 32'h00000055, 10'h030, 32'h12345678, 1'b1, 1'b0},
    '{10'h020, 32'h0BADF00D, 10'h020, 32'h0BADF00D, 1'b0, 1'b0},
    '{10'h010, 32'h000000FF, 10'h010, 32'h000000FF, 1'b0, 1'b0},
    '{10'h3FC, 32'h00000000, 10'h0FC, 32'h00000000, 1'b1, 1'b0}
  };
  localparam string VTAG [10] = '{"R2", "R1", "R6", "R7", "R7", "R7", "R4", "R5", "R8", "R4"};

  function automatic logic [31:0] expect_code(int unsigned d);
    int unsigned n = 0;
    int unsigned v = d;
    while (v > 1) begin
      v = v / 2;
      n++;
    end
    return 32'(n + ((d >= 8) ? 1 : 0));
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Returns at the negedge after the access edge, where the pulses are visible.
  task automatic bus_write(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(logic [9:0] a, output logic [31:0] d, output logic [31:0] d2);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata; d2 = prdata2;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] r, r2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    check("R11", "bad_access after reset", 32'(bad_access), 0);
    check("R11", "remap_unsup after reset", 32'(remap_unsup), 0);
    bus_read(10'h020, r, r2);
    check("R5", "pll low reset", r, 32'h021A2358);
    bus_read(10'h024, r, r2);
    check("R6", "pll status reset", r, 32'h3);
    check("R11", "no bad pulse on in-range read", 32'(bad_access), 0);
    bus_read(10'h010, r, r2);
    check("R8", "clkcfg reset div 32/8", r, (expect_code(32) << 5) | (expect_code(8) << 2));
    check("R9", "clkcfg codes 6/4", r, 32'h000000D0);
    check("R9", "clkcfg reset div 1/4", r2, (expect_code(1) << 5) | (expect_code(4) << 2));
    check("R8", "clkcfg codes 0/2", r2, 32'h00000008);
    bus_read(10'h000, r, r2);
    check("R7", "sram remap reset", r, 0);
    bus_read(10'h014, r, r2);
    check("R10", "word 5 reset", r, 0);
    bus_read(10'h0FC, r, r2);
    check("R10", "word 63 reset", r, 0);

    // Vector table
    for (int i = 0; i < 10; i++) begin
      bus_write(VECS[i].waddr, VECS[i].wdata);
      check(VTAG[i], $sformatf("vec %0d bad pulse", i), 32'(bad_access), 32'(VECS[i].ebad));
      check(VTAG[i], $sformatf("vec %0d remap pulse", i), 32'(remap_unsup), 32'(VECS[i].eremap));
      @(negedge clk);
      check("R11", $sformatf("vec %0d pulses cleared", i), 32'(bad_access | remap_unsup), 0);
      bus_read(VECS[i].raddr, r, r2);
      check(VTAG[i], $sformatf("vec %0d readback", i), r, VECS[i].rexp);
    end

    // Out-of-range read
    bus_read(10'h100, r, r2);
    check("R3", "oor read data", r, 0);
    check("R3", "oor read pulse", 32'(bad_access), 1);
    @(negedge clk);
    check("R11", "oor pulse one cycle", 32'(bad_access), 0);

    // Setup phase only, out of range: no pulse
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 10'h300; pwdata = 32'h1;
    #1;
    check("R3", "oor data during setup", prdata, 0);
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    check("R11", "setup-only no bad pulse", 32'(bad_access), 0);
    @(negedge clk);
    check("R11", "setup-only still quiet", 32'(bad_access), 0);

    finish_run();
  end
endmodule